// File: doc/BRIEF.md
# Incrementing-Pattern SRAM Writer with Pulse-Stepped Readback

This block drives an external asynchronous parallel SRAM (128K x 8 by default) for a memory and clock bring-up test. While a write-mode line is held high, it stores an 8-bit counting pattern into consecutive locations, one location per clock. While write mode is low, the SRAM is put in read mode. An external microcontroller then walks through memory one location per pulse on a separate step line and samples the data bus.

The SRAM chip-select is the system clock itself, forced inactive by reset. Each clock therefore opens one SRAM access window during the low half of the cycle. Address, pattern, write and output enables are all registered, so they are stable before the window opens. The step line is asynchronous to the block. It passes through a two-flop synchroniser and one more history register, and a single rising edge is taken from them. A slow or long pulse then advances the address exactly once.

Top module: `sram_pattern_rig`

## Requirements
- R1: While `rst` is low, `sram_ce_n` is low exactly while `clk` is low and high while `clk` is high. While `rst` is high, `sram_ce_n` stays high.
- R2: On every clock edge that samples `wr_mode` high, the block presents a write of the current pattern at the current address in the following cycle (`sram_we_n` low). The next write then uses address+1 and pattern+1.
- R3: The pattern is a PAT_W-bit (default 8) counter that wraps from 255 to 0.
- R4: The address is ADDR_W bits wide (default 17, 131072 locations) and wraps from the last location to 0.
- R5: In read mode, each rising edge on `rd_step` advances `sram_addr` by exactly one, visible within 4 clocks. Holding `rd_step` high for many clocks causes no further advance.
- R6: `rd_step` is synchronised by two flip-flops plus one edge-history register. A pulse that is high across a single clock edge is still counted once.
- R7: The block drives `sram_dq` only in write cycles (`sram_we_n` low). In all other cycles, including reset and read mode, its driver is high impedance.
- R8: In read mode (`wr_mode` low, not in reset), `sram_oe_n` is low and `sram_we_n` is high, so the SRAM drives the bus during the chip-select window.
- R9: Synchronous reset clears the address and pattern to 0 and sets `sram_we_n` and `sram_oe_n` high.
- R10: When `wr_mode` is high, `rd_step` edges are ignored. The address advances only by the number of write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the SRAM chip-select source |
| rst | input | 1 | Synchronous reset, active high |
| wr_mode | input | 1 | Write-mode request from the microcontroller |
| rd_step | input | 1 | Asynchronous read-step pulse from the microcontroller |
| sram_addr | output | ADDR_W | SRAM address, registered |
| sram_ce_n | output | 1 | SRAM chip enable, active low (clock gated by reset) |
| sram_we_n | output | 1 | SRAM write enable, active low, registered |
| sram_oe_n | output | 1 | SRAM output enable, active low, registered |
| sram_dq | inout | PAT_W | SRAM data bus |

## Verification
The bench uses a 5-bit address, so 32 locations. It writes 300 consecutive cycles, which wraps the address many times and the pattern once. Each location then ends holding a value that is predictable by arithmetic, and this separates a wrong address wrap from a wrong pattern wrap. Step pulses are sent during the write burst. Checking the final address tells whether write mode kept priority over them.

Readback tests three kinds of step:
- single-cycle pulses, which would be lost by a design without synchronisation;
- a full 32-step sweep, which checks the address return to 0;
- one pulse held high for ten cycles, which shows whether the address advances on the level or on the edge.

// File: rtl/sram_rig_pkg.sv
package sram_rig_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2
  } bus_mode_t;

endpackage

// File: rtl/rig_step_edge.sv
module rig_step_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic step_async,
  output logic step_rise
);

  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN-2:0], step_async};
  end

  // synchronised level is chain_q[SYNC_STAGES-1]; the history bit is one cycle older
  assign step_rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/rig_counters.sv
module rig_counters #(
  parameter int ADDR_W = 17,
  parameter int PAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_step,
  input  logic              rd_step,
  output logic [ADDR_W-1:0] addr_q,
  output logic [PAT_W-1:0]  pat_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      pat_q  <= '0;
    end else begin
      if (wr_step || rd_step) addr_q <= addr_q + 1'b1;
      if (wr_step)            pat_q  <= pat_q + 1'b1;
    end
  end

endmodule

// File: rtl/rig_bus_ctrl.sv
module rig_bus_ctrl
  import sram_rig_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int PAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_mode_t         mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAT_W-1:0]  pat,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PAT_W-1:0]  dout_o,
  output logic              drive_o,
  output logic              we_n_o,
  output logic              oe_n_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      dout_o  <= '0;
      drive_o <= 1'b0;
      we_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
    end else begin
      addr_o <= addr;
      unique case (mode)
        BUS_WRITE: begin
          dout_o  <= pat;
          drive_o <= 1'b1;
          we_n_o  <= 1'b0;
          oe_n_o  <= 1'b1;
        end
        BUS_READ: begin
          drive_o <= 1'b0;
          we_n_o  <= 1'b1;
          oe_n_o  <= 1'b0;
        end
        default: begin
          drive_o <= 1'b0;
          we_n_o  <= 1'b1;
          oe_n_o  <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/sram_pattern_rig.sv
module sram_pattern_rig
  import sram_rig_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int PAT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mode,
  input  logic              rd_step,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  inout  wire  [PAT_W-1:0]  sram_dq
);

  logic              step_rise;
  logic [ADDR_W-1:0] addr_q;
  logic [PAT_W-1:0]  pat_q;
  logic [PAT_W-1:0]  dout_q;
  logic              drive_q;
  bus_mode_t         mode;

  rig_step_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .step_async (rd_step),
    .step_rise  (step_rise)
  );

  assign mode = wr_mode ? BUS_WRITE : BUS_READ;

  rig_counters #(.ADDR_W(ADDR_W), .PAT_W(PAT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .wr_step (wr_mode),
    .rd_step (step_rise & ~wr_mode),
    .addr_q  (addr_q),
    .pat_q   (pat_q)
  );

  rig_bus_ctrl #(.ADDR_W(ADDR_W), .PAT_W(PAT_W)) u_bus (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .addr    (addr_q),
    .pat     (pat_q),
    .addr_o  (sram_addr),
    .dout_o  (dout_q),
    .drive_o (drive_q),
    .we_n_o  (sram_we_n),
    .oe_n_o  (sram_oe_n)
  );

  // one access window per clock: select is active during the low half
  assign sram_ce_n = clk | rst;
  assign sram_dq   = drive_q ? dout_q : {PAT_W{1'bz}};

endmodule

// File: rtl/sram_rig_chk.sv
module sram_rig_chk #(
  parameter int ADDR_W = 17,
  parameter int PAT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_mode,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              drive_q,
  input logic [PAT_W-1:0]  dout_q
);

  // R2, R3, R4: back-to-back writes step address and pattern by one, modulo width
  a_r2_write_step: assert property (@(posedge clk) disable iff (rst)
    (!sram_we_n && !$past(sram_we_n)) |->
      (sram_addr == ADDR_W'($past(sram_addr) + 1'b1)) &&
      (dout_q == PAT_W'($past(dout_q) + 1'b1)));

  // R5: in read mode the address moves by at most one per cycle
  a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
    (sram_we_n && $past(sram_we_n)) |->
      (sram_addr == $past(sram_addr)) ||
      (sram_addr == ADDR_W'($past(sram_addr) + 1'b1)));

  // R7: bus driven only while a write is presented
  a_r7_drive_only_write: assert property (@(posedge clk) disable iff (rst)
    drive_q == !sram_we_n);

  // R8: read mode enables outputs and blocks writes
  a_r8_read_ctrl: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_mode)) |-> (!sram_oe_n && sram_we_n));

  // R9: reset state of the control lines and address
  a_r9_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (sram_we_n && sram_oe_n && !drive_q && sram_addr == '0));

  // R10: write mode wins every cycle it is sampled
  a_r10_write_priority: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_mode)) |-> (!sram_we_n && sram_oe_n));

endmodule

bind sram_pattern_rig sram_rig_chk #(.ADDR_W(ADDR_W), .PAT_W(PAT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_mode   (wr_mode),
  .sram_addr (sram_addr),
  .sram_we_n (sram_we_n),
  .sram_oe_n (sram_oe_n),
  .drive_q   (drive_q),
  .dout_q    (dout_q)
);

// File: tb/sim_sram_pattern_rig.sv
`timescale 1ns/1ps
module sim_sram_pattern_rig;

  localparam int AW = 5;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int NWR = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_mode = 1'b0;
  logic rd_step = 1'b0;
  logic [AW-1:0] sram_addr;
  logic sram_ce_n, sram_we_n, sram_oe_n;
  wire  [DW-1:0] sram_dq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sram_pattern_rig #(.ADDR_W(AW), .PAT_W(DW)) u0 (
    .clk(clk), .rst(rst), .wr_mode(wr_mode), .rd_step(rd_step),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq(sram_dq)
  );

  // asynchronous SRAM model
  logic [DW-1:0] mem [DEPTH];
  always @(negedge sram_ce_n) if (!sram_we_n) mem[sram_addr] <= sram_dq;
  assign sram_dq = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr] : {DW{1'bz}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] stored(input int a);
    int last = a + ((NWR - 1 - a) / DEPTH) * DEPTH;
    return DW'(last % 256);
  endfunction

  task automatic pulse_step();
    @(negedge clk) rd_step = 1'b1;
    @(negedge clk) rd_step = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    // reset phase: R1, R7, R9
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    check("R1 ce high in reset (clk high)", sram_ce_n, 1);
    @(negedge clk); #1;
    check("R1 ce high in reset (clk low)", sram_ce_n, 1);
    check("R9 we_n in reset", sram_we_n, 1);
    check("R9 oe_n in reset", sram_oe_n, 1);
    check("R9 addr in reset", sram_addr, 0);
    check("R7 bus z in reset", (sram_dq === {DW{1'bz}}), 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check("R1 ce low while clk low", sram_ce_n, 0);
    check("R8 oe_n low in read", sram_oe_n, 0);
    check("R8 we_n high in read", sram_we_n, 1);
    @(posedge clk); #1;
    check("R1 ce high while clk high", sram_ce_n, 1);
    check("R7 bus z in read high phase", (sram_dq === {DW{1'bz}}), 1);

    // write burst with step pulses interleaved: R2, R3, R4, R10
    @(negedge clk) wr_mode = 1'b1;
    for (int i = 0; i < NWR; i++) begin
      @(negedge clk);
      #1;
      rd_step = (i >= 50 && i < 52) || (i >= 120 && i < 121);
      check("R2 we_n low in write", sram_we_n, 0);
      check("R4 write address", sram_addr, i % DEPTH);
      check("R3 write pattern", sram_dq, i % 256);
      if (i == NWR - 1) wr_mode = 1'b0;
    end
    rd_step = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    check("R10 steps ignored during write", sram_addr, NWR % DEPTH);
    check("R7 bus released after write", sram_we_n, 1);

    // readback sweep from 0: R5, R6, R4 wrap
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check("R9 addr cleared", sram_addr, 0);
    check("R5 read data at 0", sram_dq, stored(0));
    for (int a = 1; a <= DEPTH; a++) begin
      pulse_step();
      #1;
      check("R6 one-cycle pulse step", sram_addr, a % DEPTH);
      check("R5 read data", sram_dq, stored(a % DEPTH));
      @(posedge clk); #1;
      check("R7 bus z outside window", (sram_dq === {DW{1'bz}}), 1);
    end

    // held step level advances once: R5
    @(negedge clk) rd_step = 1'b1;
    repeat (10) @(negedge clk);
    #1;
    check("R5 held step advances once", sram_addr, 1);
    rd_step = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    check("R5 release causes no step", sram_addr, 1);
    check("R5 read data after held step", sram_dq, stored(1));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule